// File: doc/BRIEF.md
# Multi-mode pulse interval timer

This block measures time on one or two digital inputs, A and B, in system-clock cycles. Both inputs are resynchronised and then edge-detected. A start strobe latches the measurement configuration and arms the counters. There are four mode and sub-mode pairs in total. A single A rise can capture the elapsed count and restart it. The block can report the width of each A high level. It can sum the high time of X pulses. It can sum X intervals, each running from an A rise to a selected B transition.

Summing over several pulses lets a slower system clock reach the same resolution per count, because the total is divided afterwards. With B wired to the inverse of A, the interval mode with the B-rising sub-mode measures A's high time.

Every measurement goes into a result register and raises a ready flag. The flag holds until it is acknowledged. Results that arrive while the flag is still up are flagged as overruns. Counts stop at all-ones and never wrap.

Top module: `pulse_timer`

## Requirements
- R1: A and B each pass through two synchronising flops, and edges are judged against one more registered copy. A result caused by an A rise becomes visible on the third rising clock edge after the rise is applied, and not on the second.
- R2: `start_i` latches `mode_i`, `bsel_i` and `xcount_i`, clears all counters, and clears `result_o`, `ready_o`, `overrun_o` and `sat_o` on the next edge. No result is produced after reset until the first start.
- R3: Mode 0 (capture). Each A rise publishes the number of cycles since the previous A rise, or since the start strobe, and restarts the count.
- R4: Mode 1 (high width). The count grows on every cycle A is high. Each A fall publishes that count and clears it.
- R5: Mode 2 (X highs). High-level cycles of A are summed. The sum is published at the X-th A fall and then restarts.
- R6: Mode 3 (X intervals). An interval opens on an A rise and closes on the selected B transition. It contributes the cycle distance between the two. The sum of X intervals is published. A rises while an interval is open are ignored, and so are B transitions while no interval is open.
- R7: `bsel_i`=0 closes an interval only on a B rise. `bsel_i`=1 closes it on either B transition.
- R8: An X count of 0 behaves as 1.
- R9: `ready_o` rises with each result and stays high until `ack_i`. An acknowledge in the same cycle as a new result leaves it high.
- R10: A result that arrives while `ready_o` is high and not being acknowledged sets `overrun_o`. It stays set until the next start.
- R11: Counts saturate at all-ones. `sat_o` is high exactly while the held result equals all-ones.
- R12: `result_o` changes only when a result is published or a start occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Measurement mode: 0 capture, 1 high width, 2 X highs, 3 X intervals |
| bsel_i | input | 1 | Interval end: 0 B rise, 1 any B change |
| xcount_i | input | XCNT_W | Pulse or interval count X |
| start_i | input | 1 | Clear and start strobe |
| ack_i | input | 1 | Result acknowledge |
| a_i | input | 1 | Asynchronous input A |
| b_i | input | 1 | Asynchronous input B |
| result_o | output | CNT_W | Latest measurement in clock cycles |
| ready_o | output | 1 | Unacknowledged result present |
| overrun_o | output | 1 | A result was overwritten before acknowledge |
| sat_o | output | 1 | Held result is saturated |

## Verification
The bench builds the block with CNT_W=10 and XCNT_W=4. With those values a capture left idle for about a thousand cycles reaches the all-ones ceiling, so saturation, and the unsaturated result that follows it, are checked without long runs. The four-bit X keeps the X=0 case and multi-pulse sums short. The B-equals-inverse-of-A wiring is driven as well, which checks that the interval mode agrees with the high-width mode.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    PM_CAPTURE = 2'd0,
    PM_HIGH    = 2'd1,
    PM_XHIGH   = 2'd2,
    PM_XPERIOD = 2'd3
  } pit_mode_e;
endpackage

// File: rtl/pit_edge.sv
module pit_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/pit_engine.sv
module pit_engine
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int XCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              bsel_i,
  input  logic [XCNT_W-1:0] xcount_i,
  input  logic [1:0]        lvl_i,
  input  logic [1:0]        prev_i,
  output logic              pub_o,
  output logic [CNT_W-1:0]  pub_val_o,
  output logic              run_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [XCNT_W-1:0] X_ONE   = XCNT_W'(1);

  pit_mode_e         mode_q;
  logic              bsel_q, run_q, open_q, open_d;
  logic [XCNT_W-1:0] x_q, pcnt_q, pcnt_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic              a_lvl, a_rise, a_fall, b_evt, last_pulse;
  logic [XCNT_W:0]   pcnt_next;

  assign a_lvl  = lvl_i[0];
  assign a_rise = lvl_i[0] & ~prev_i[0];
  assign a_fall = ~lvl_i[0] & prev_i[0];
  // bsel 0: B rise only; bsel 1: either B transition
  assign b_evt  = bsel_q ? (lvl_i[1] ^ prev_i[1]) : (lvl_i[1] & ~prev_i[1]);

  assign cnt_inc    = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign pcnt_next  = {1'b0, pcnt_q} + 1'b1;
  assign last_pulse = pcnt_next >= {1'b0, x_q};

  always_comb begin
    cnt_d     = cnt_q;
    pcnt_d    = pcnt_q;
    open_d    = open_q;
    pub_o     = 1'b0;
    pub_val_o = cnt_q;
    if (run_q && !start_i) begin
      unique case (mode_q)
        PM_CAPTURE: begin
          if (a_rise) begin
            pub_o     = 1'b1;
            pub_val_o = cnt_inc;
            cnt_d     = '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        PM_HIGH: begin
          if (a_fall) begin
            pub_o = 1'b1;
            cnt_d = '0;
          end else if (a_lvl) begin
            cnt_d = cnt_inc;
          end
        end
        PM_XHIGH: begin
          if (a_lvl) begin
            cnt_d = cnt_inc;
          end else if (a_fall) begin
            if (last_pulse) begin
              pub_o  = 1'b1;
              cnt_d  = '0;
              pcnt_d = '0;
            end else begin
              pcnt_d = pcnt_next[XCNT_W-1:0];
            end
          end
        end
        PM_XPERIOD: begin
          if (open_q) begin
            if (b_evt) begin
              open_d = 1'b0;
              if (last_pulse) begin
                pub_o     = 1'b1;
                pub_val_o = cnt_inc;
                cnt_d     = '0;
                pcnt_d    = '0;
              end else begin
                cnt_d  = cnt_inc;
                pcnt_d = pcnt_next[XCNT_W-1:0];
              end
            end else begin
              cnt_d = cnt_inc;
            end
          end else if (a_rise) begin
            open_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PM_CAPTURE;
      bsel_q <= 1'b0;
      x_q    <= X_ONE;
      run_q  <= 1'b0;
      open_q <= 1'b0;
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else if (start_i) begin
      mode_q <= pit_mode_e'(mode_i);
      bsel_q <= bsel_i;
      x_q    <= (xcount_i == '0) ? X_ONE : xcount_i;
      run_q  <= 1'b1;
      open_q <= 1'b0;
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/pit_result.sv
module pit_result #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ack_i,
  input  logic             pub_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [CNT_W-1:0] result_o,
  output logic             ready_o,
  output logic             overrun_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      ready_o   <= 1'b0;
      overrun_o <= 1'b0;
      sat_o     <= 1'b0;
    end else if (start_i) begin
      result_o  <= '0;
      ready_o   <= 1'b0;
      overrun_o <= 1'b0;
      sat_o     <= 1'b0;
    end else if (pub_i) begin
      result_o <= val_i;
      ready_o  <= 1'b1;
      sat_o    <= (val_i == CNT_MAX);
      if (ready_o && !ack_i) overrun_o <= 1'b1;
    end else if (ack_i) begin
      ready_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int CNT_W  = 16,
  parameter int XCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              bsel_i,
  input  logic [XCNT_W-1:0] xcount_i,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic              a_i,
  input  logic              b_i,
  output logic [CNT_W-1:0]  result_o,
  output logic              ready_o,
  output logic              overrun_o,
  output logic              sat_o
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] raw_w, lvl_w, prev_w;
  logic            pub_w, run_w;
  logic [CNT_W-1:0] pub_val_w;

  assign raw_w = {b_i, a_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    pit_edge #(.STAGES(2)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_w[g]),
      .lvl_o  (lvl_w[g]),
      .prev_o (prev_w[g])
    );
  end

  pit_engine #(.CNT_W(CNT_W), .XCNT_W(XCNT_W)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .bsel_i    (bsel_i),
    .xcount_i  (xcount_i),
    .lvl_i     (lvl_w),
    .prev_i    (prev_w),
    .pub_o     (pub_w),
    .pub_val_o (pub_val_w),
    .run_o     (run_w)
  );

  pit_result #(.CNT_W(CNT_W)) u_result (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .ack_i     (ack_i),
    .pub_i     (pub_w),
    .val_i     (pub_val_w),
    .result_o  (result_o),
    .ready_o   (ready_o),
    .overrun_o (overrun_o),
    .sat_o     (sat_o)
  );
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             ack_i,
  input logic             pub_i,
  input logic             run_i,
  input logic [CNT_W-1:0] result_i,
  input logic             ready_i,
  input logic             overrun_i,
  input logic             sat_i
);
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!ready_i && !overrun_i && !sat_i && result_i == '0));

  a_r2_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !pub_i);

  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !pub_i && !start_i) |=> !ready_i);

  a_r9_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !ack_i && !start_i) |=> ready_i);

  a_r10_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pub_i && ready_i && !ack_i && !start_i) |=> overrun_i);

  a_r10_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_i && !start_i) |=> overrun_i);

  a_r11_sat_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_i |-> (result_i == {CNT_W{1'b1}}));

  a_r12_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pub_i && !start_i) |=> $stable(result_i));
endmodule

bind pulse_timer pit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .ack_i     (ack_i),
  .pub_i     (pub_w),
  .run_i     (run_w),
  .result_i  (result_o),
  .ready_i   (ready_o),
  .overrun_i (overrun_o),
  .sat_i     (sat_o)
);

// File: tb/tb_pulse_timer.sv
`timescale 1ns/1ps
module tb_pulse_timer;
  localparam int CNT_W  = 10;
  localparam int XCNT_W = 4;
  localparam int MAXV   = (1 << CNT_W) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic bsel_i = 1'b0;
  logic [XCNT_W-1:0] xcount_i = '0;
  logic start_i = 1'b0, ack_i = 1'b0, a_i = 1'b0, b_i = 1'b0;
  logic [CNT_W-1:0] result_o;
  logic ready_o, overrun_o, sat_o;

  int checks = 0, failures = 0;
  bit done = 0, cmp_en = 0;
  string cur_req = "R2";

  always #2.5 clk_i = ~clk_i;

  pulse_timer #(.CNT_W(CNT_W), .XCNT_W(XCNT_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .bsel_i(bsel_i),
    .xcount_i(xcount_i), .start_i(start_i), .ack_i(ack_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .ready_o(ready_o), .overrun_o(overrun_o), .sat_o(sat_o)
  );

  // behavioural reference
  int a_pipe[$], b_pipe[$];
  int m_run, m_mode, m_bsel, m_x, m_rem, m_cnt, m_open;
  int m_res, m_rdy, m_ovr, m_sat;

  function automatic int bump(int v);
    return (v >= MAXV) ? MAXV : v + 1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_pipe = '{0, 0, 0}; b_pipe = '{0, 0, 0};
      m_run = 0; m_mode = 0; m_bsel = 0; m_x = 1; m_rem = 1; m_cnt = 0; m_open = 0;
      m_res = 0; m_rdy = 0; m_ovr = 0; m_sat = 0;
    end else begin
      // pipe index 0 = prev, 1 = level, 2 = first stage
      int al, ap, bl, bp, pub, val;
      bit ar, af, bev;
      al = a_pipe[1]; ap = a_pipe[0]; bl = b_pipe[1]; bp = b_pipe[0];
      ar = al && !ap; af = !al && ap;
      bev = m_bsel ? (bl != bp) : (bl && !bp);
      pub = 0; val = 0;
      if (start_i) begin
        m_run = 1; m_mode = mode_i; m_bsel = bsel_i;
        m_x = (xcount_i == 0) ? 1 : int'(xcount_i);
        m_rem = m_x; m_cnt = 0; m_open = 0;
        m_res = 0; m_rdy = 0; m_ovr = 0; m_sat = 0;
      end else begin
        if (m_run) begin
          case (m_mode)
            0: if (ar) begin pub = 1; val = bump(m_cnt); m_cnt = 0; end
               else m_cnt = bump(m_cnt);
            1: if (af) begin pub = 1; val = m_cnt; m_cnt = 0; end
               else if (al) m_cnt = bump(m_cnt);
            2: if (al) m_cnt = bump(m_cnt);
               else if (af) begin
                 if (m_rem == 1) begin pub = 1; val = m_cnt; m_cnt = 0; m_rem = m_x; end
                 else m_rem--;
               end
            default: if (m_open) begin
                m_cnt = bump(m_cnt);
                if (bev) begin
                  m_open = 0;
                  if (m_rem == 1) begin pub = 1; val = m_cnt; m_cnt = 0; m_rem = m_x; end
                  else m_rem--;
                end
              end else if (ar) m_open = 1;
          endcase
        end
        if (pub) begin
          if (m_rdy && !ack_i) m_ovr = 1;
          m_res = val; m_rdy = 1; m_sat = (val == MAXV);
        end else if (ack_i) m_rdy = 0;
      end
      void'(a_pipe.pop_front()); a_pipe.push_back(int'(a_i));
      void'(b_pipe.pop_front()); b_pipe.push_back(int'(b_i));
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && cmp_en && !done) begin
      checks++;
      if (int'(result_o) != m_res || int'(ready_o) != m_rdy ||
          int'(overrun_o) != m_ovr || int'(sat_o) != m_sat) begin
        failures++;
        $display("FAIL %s model: actual res=%0d rdy=%0d ovr=%0d sat=%0d expected res=%0d rdy=%0d ovr=%0d sat=%0d",
                 cur_req, result_o, ready_o, overrun_o, sat_o, m_res, m_rdy, m_ovr, m_sat);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(int mode, int bsel, int x);
    mode_i = mode[1:0]; bsel_i = bsel[0]; xcount_i = x[XCNT_W-1:0];
    start_i = 1'b1; tick(1); start_i = 1'b0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1; tick(1); ack_i = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 60; i++) begin
      if (ready_o) break;
      tick(1);
    end
  endtask

  task automatic settle(int av, int bv);
    a_i = av[0]; b_i = bv[0]; tick(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    cur_req = "R2";
    chk("R2 reset result", int'(result_o), 0);
    chk("R2 reset ready", int'(ready_o), 0);
    rst_ni = 1'b1; tick(1);
    cmp_en = 1;
    // no start yet: edges must not publish
    a_i = 1; tick(4); a_i = 0; tick(6);
    chk("R2 idle before start", int'(ready_o), 0);

    // R4 high width
    cur_req = "R4";
    do_start(1, 0, 1);
    a_i = 1; tick(7); a_i = 0;
    wait_ready();
    chk("R4 high width", int'(result_o), 7);
    cur_req = "R9";
    tick(10);
    chk("R9 ready held", int'(ready_o), 1);
    do_ack();
    chk("R9 ack clears", int'(ready_o), 0);
    cur_req = "R12";
    tick(8);
    chk("R12 result held", int'(result_o), 7);

    // R10 overrun: two pulses without ack
    cur_req = "R10";
    a_i = 1; tick(3); a_i = 0; tick(4); a_i = 1; tick(5); a_i = 0; tick(8);
    chk("R10 newest result", int'(result_o), 5);
    chk("R10 overrun", int'(overrun_o), 1);
    do_ack(); tick(3);
    chk("R10 sticky after ack", int'(overrun_o), 1);
    cur_req = "R2";
    do_start(0, 0, 1);
    chk("R2 start clears overrun", int'(overrun_o), 0);
    chk("R2 start clears result", int'(result_o), 0);

    // R1 latency in capture mode
    cur_req = "R1";
    tick(5);
    a_i = 1; tick(2);
    chk("R1 not yet after 2 edges", int'(ready_o), 0);
    tick(1);
    chk("R1 visible after 3 edges", int'(ready_o), 1);
    a_i = 0; tick(2); do_ack();

    // R3 capture spacing: rises 13 cycles apart
    cur_req = "R3";
    a_i = 1; tick(3); a_i = 0; tick(10); a_i = 1; tick(4);
    chk("R3 capture interval", int'(result_o), 13);
    a_i = 0; tick(3); do_ack();

    // R11 saturation
    cur_req = "R11";
    do_start(0, 0, 1);
    tick(1100);
    a_i = 1; tick(3);
    chk("R11 saturated value", int'(result_o), MAXV);
    chk("R11 sat flag", int'(sat_o), 1);
    a_i = 0; tick(2); a_i = 1; tick(3);
    chk("R11 next capture", int'(result_o), 5);
    chk("R11 sat cleared", int'(sat_o), 0);
    settle(0, 0);

    // R5 X highs, X=3
    cur_req = "R5";
    do_start(2, 0, 3);
    a_i = 1; tick(4); a_i = 0; tick(3);
    a_i = 1; tick(5); a_i = 0; tick(6);
    chk("R5 no result before X", int'(ready_o), 0);
    a_i = 1; tick(6); a_i = 0;
    wait_ready();
    chk("R5 sum of three", int'(result_o), 15);
    do_ack();

    // R8 X=0 acts as 1
    cur_req = "R8";
    do_start(2, 0, 0);
    a_i = 1; tick(6); a_i = 0;
    wait_ready();
    chk("R8 x zero", int'(result_o), 6);
    do_ack(); settle(0, 1);

    // R6 with B = ~A, sub-mode 0: two intervals equal high times
    cur_req = "R6";
    do_start(3, 0, 2);
    a_i = 1; b_i = 0; tick(5); a_i = 0; b_i = 1; tick(4);
    a_i = 1; b_i = 0; tick(8); a_i = 0; b_i = 1;
    wait_ready();
    chk("R6 inverse-B high sum", int'(result_o), 13);
    do_ack(); settle(0, 0);

    // R6 extra A rise inside an open interval ignored
    do_start(3, 0, 1);
    a_i = 1; tick(2); a_i = 0; tick(2); a_i = 1; tick(6); b_i = 1;
    wait_ready();
    chk("R6 inner A rise ignored", int'(result_o), 10);
    do_ack(); settle(0, 1);

    // R7 sub-mode 0 ignores B fall
    cur_req = "R7";
    do_start(3, 0, 1);
    a_i = 1; tick(4); b_i = 0; tick(5); b_i = 1;
    wait_ready();
    chk("R7 rise only", int'(result_o), 9);
    do_ack(); settle(0, 1);

    // R7 sub-mode 1 ends on B fall
    do_start(3, 1, 1);
    a_i = 1; tick(6); b_i = 0;
    wait_ready();
    chk("R7 any change", int'(result_o), 6);
    do_ack(); settle(0, 0);

    // R9 ack together with new result keeps ready
    cur_req = "R9";
    do_start(1, 0, 1);
    a_i = 1; tick(3); a_i = 0; wait_ready(); tick(1);
    a_i = 1; tick(4); a_i = 0; tick(2);
    ack_i = 1; tick(1); ack_i = 0;
    chk("R9 ack with new result", int'(ready_o), 1);
    chk("R9 no overrun on ack", int'(overrun_o), 0);
    tick(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule